// File: doc/BRIEF.md
# Self-Triggered Transient Width Capture

This block is a cycle-level, synthesizable model of a structure that measures the width of a transient disturbance without being told when it arrives. A chain of inverting stages advances one stage per clock. Each stage output feeds a transparent capture latch. A disturbance of programmable length, in clocks, is injected at a chosen stage below the trigger stage. When its leading edge reaches the trigger stage, a sticky control flag is set. After a fixed lag, the flag drops `pass_o` and raises `hold_o`, which stops the chain and freezes every latch. During the lag the edge keeps moving, so the frozen snapshot holds the disturbance beyond the trigger point.

A decoder compares the frozen snapshot with the rest pattern. At rest, odd-numbered stages sit high and even-numbered stages sit low. The decoder reports how many stages are inverted, the equivalent width in picoseconds, and whether the disturbance was still being injected when the freeze happened. A serial shifter reads the snapshot out one stage per clock. A re-arm input returns the structure to its rest state.

Top module: `glitch_capture`

## Requirements
- R1: After reset, `pass_o`=1 and `hold_o`=0. `rd_busy_o`, `rd_done_o`, `flip_cnt_o`, `width_ps_o` and `sat_o` are all 0. A readout returns the rest pattern, in which stage i reads 1 when i is odd and 0 when i is even.
- R2: An accepted injection at stage k with length L inverts stage k for L clocks. The inverted run moves up by one stage per clock. At the freeze, the inverted stages are exactly those from max(k, T+2+G−L) through T+1+G, where T is the trigger stage and G is the lag.
- R3: `hold_o` rises and `pass_o` falls on the (T+2+G−k)-th clock edge after the edge that accepts the injection. The two controls stay there until re-armed.
- R4: While `hold_o` is 1, the latch contents do not change.
- R5: While `hold_o` is 1, `flip_cnt_o` equals the number of stages that differ from the rest pattern. This is min(L, T+2+G−k). `width_ps_o` equals that count times the stage delay parameter. While `hold_o` is 0, both outputs are 0.
- R6: `sat_o` is 1 while frozen when the injection stage itself is still inverted, which happens when L ≥ T+2+G−k. Otherwise `sat_o` is 0.
- R7: A `rd_go_i` pulse while idle starts a readout. `rd_busy_o` is high for exactly STAGES clocks. `ser_o` presents stage 1 in the first busy cycle, then one stage per clock in ascending order. `rd_done_o` is high for the single cycle after the last bit.
- R8: `rearm_i` returns the chain, the latches and the controls to the rest state. It is ignored while `rd_busy_o` is 1.
- R9: `rd_go_i` is ignored while a readout is in progress, so the readout length is unchanged.
- R10: An injection request is ignored once the control flag is set or the chain is frozen. This also applies while a previous injection is still active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one stage of delay per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| rearm_i | input | 1 | Return to the rest state and re-arm the trigger |
| inj_go_i | input | 1 | Request a disturbance injection |
| inj_stage_i | input | IDX_W (5) | Stage (1-based) at which to inject |
| inj_len_i | input | LEN_W (6) | Disturbance length in clocks |
| rd_go_i | input | 1 | Start serial readout of the latches |
| pass_o | output | 1 | Chain propagating |
| hold_o | output | 1 | Latches frozen |
| ser_o | output | 1 | Serial latch data, stage 1 first |
| rd_busy_o | output | 1 | Readout in progress |
| rd_done_o | output | 1 | One-cycle pulse after the last bit |
| flip_cnt_o | output | IDX_W (5) | Number of inverted stages in the snapshot |
| width_ps_o | output | WPS_W (11) | Equivalent width in picoseconds |
| sat_o | output | 1 | Injection stage still inverted at the freeze |

## Verification
The properties assume that the injection stage lies between 1 and the trigger stage minus one. They also assume that the trigger stage plus the lag stays inside the chain. Under those conditions, a change at the trigger tap can only come from an injected disturbance, and the frozen snapshot is complete. The directed tests use only stage indices below the trigger. They re-arm before every capture, and they inject only once per arming, except in the cases that deliberately check that a second injection is ignored. Lengths cover pulses that end before the freeze, pulses that exactly fill the window, and pulses longer than the window.

// File: rtl/gwp_pkg.sv
package gwp_pkg;

    localparam int MAX_STAGES = 64;

    // rest pattern: bit i is stage i+1, odd stages high
    function automatic logic [MAX_STAGES-1:0] idle_word();
        logic [MAX_STAGES-1:0] w;
        for (int i = 0; i < MAX_STAGES; i++) begin
            w[i] = (i % 2 == 0);
        end
        return w;
    endfunction

    typedef enum logic [0:0] {
        RD_IDLE  = 1'b0,
        RD_SHIFT = 1'b1
    } rd_state_e;

endpackage

// File: rtl/gwp_chain.sv
module gwp_chain #(
    parameter int STAGES = 18,
    parameter int IDX_W  = 5,
    parameter int LEN_W  = 6,
    parameter int TRIG   = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              go,
    input  logic              flag,
    input  logic              hold,
    input  logic [IDX_W-1:0]  sel,
    input  logic [LEN_W-1:0]  len,
    output logic [STAGES-1:0] lat_o,
    output logic [IDX_W-1:0]  site_o,
    output logic              tap_o
);
    localparam logic [gwp_pkg::MAX_STAGES-1:0] IDLE_W = gwp_pkg::idle_word();
    localparam logic [STAGES-1:0] IDLE = IDLE_W[STAGES-1:0];

    typedef struct packed {
        logic [STAGES-1:0] stg;
        logic [STAGES-1:0] lat;
        logic [LEN_W-1:0]  left;
        logic [IDX_W-1:0]  site;
    } chain_t;

    chain_t            st_q, st_d;
    logic              hit;
    logic              accept;
    logic [STAGES-1:0] prev;

    always_comb begin
        st_d   = st_q;
        hit    = (st_q.left != '0);
        accept = go && !flag && !hold && !hit && (sel != '0);
        prev   = {st_q.stg[STAGES-2:0], 1'b0};
        if (!hold) begin
            for (int i = 0; i < STAGES; i++) begin
                st_d.stg[i] = ~prev[i] ^ (hit && (st_q.site == IDX_W'(i + 1)));
            end
            // transparent latch follows its stage while not held
            st_d.lat = st_d.stg;
            if (hit) begin
                st_d.left = st_q.left - 1'b1;
            end
            if (accept) begin
                st_d.left = len;
                st_d.site = sel;
            end
        end
        if (clr) begin
            st_d.stg  = IDLE;
            st_d.lat  = IDLE;
            st_d.left = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= chain_t'{stg: IDLE, lat: IDLE, left: '0, site: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign lat_o  = st_q.lat;
    assign site_o = st_q.site;
    assign tap_o  = st_q.stg[TRIG-1];

    AST_LATCH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !clr) |=> $stable(st_q.lat)); // R4

    AST_NO_INJECT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (go && (flag || hold) && !clr) |=> $stable(st_q.site)); // R10

endmodule

// File: rtl/gwp_trigger.sv
module gwp_trigger #(
    parameter int   LAG      = 2,
    parameter logic IDLE_TAP = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tap,
    output logic flag_o,
    output logic hold_o
);
    typedef struct packed {
        logic           flag;
        logic [LAG-1:0] pipe;
    } trig_t;

    trig_t tr_q, tr_d;

    always_comb begin
        tr_d         = tr_q;
        tr_d.flag    = tr_q.flag | (tap != IDLE_TAP);
        tr_d.pipe[0] = tr_q.flag;
        for (int i = 1; i < LAG; i++) begin
            tr_d.pipe[i] = tr_q.pipe[i-1];
        end
        if (clr) begin
            tr_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tr_q <= '0;
        end else begin
            tr_q <= tr_d;
        end
    end

    assign flag_o = tr_q.flag;
    assign hold_o = tr_q.pipe[LAG-1];

    AST_TRIG_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ((tap != IDLE_TAP) && !clr) |=> flag_o); // R3

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr) |=> flag_o); // R3

    AST_HOLD_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |-> flag_o); // R3

endmodule

// File: rtl/gwp_decode.sv
module gwp_decode #(
    parameter int STAGES   = 18,
    parameter int IDX_W    = 5,
    parameter int WPS_W    = 11,
    parameter int STAGE_PS = 65
) (
    input  logic [STAGES-1:0] lat,
    input  logic [IDX_W-1:0]  site,
    input  logic              hold,
    output logic [IDX_W-1:0]  cnt_o,
    output logic [WPS_W-1:0]  width_o,
    output logic              sat_o
);
    localparam logic [gwp_pkg::MAX_STAGES-1:0] IDLE_W = gwp_pkg::idle_word();
    localparam logic [STAGES-1:0] IDLE = IDLE_W[STAGES-1:0];

    logic [STAGES-1:0] diff;
    logic [IDX_W-1:0]  cnt_v;
    logic              sat_v;

    always_comb begin
        diff  = lat ^ IDLE;
        cnt_v = '0;
        sat_v = 1'b0;
        for (int i = 0; i < STAGES; i++) begin
            cnt_v = cnt_v + IDX_W'(diff[i]);
            if (diff[i] && (site == IDX_W'(i + 1))) begin
                sat_v = 1'b1;
            end
        end
        if (!hold) begin
            cnt_v = '0;
            sat_v = 1'b0;
        end
        cnt_o   = cnt_v;
        width_o = WPS_W'(int'(cnt_v) * STAGE_PS);
        sat_o   = sat_v;
    end

endmodule

// File: rtl/gwp_readout.sv
module gwp_readout #(
    parameter int STAGES = 18,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [STAGES-1:0] lat,
    output logic              ser_o,
    output logic              busy_o,
    output logic              done_o
);
    import gwp_pkg::*;

    typedef struct packed {
        rd_state_e         state;
        logic [STAGES-1:0] sh;
        logic [IDX_W-1:0]  cnt;
        logic              done;
    } rd_t;

    rd_t rd_q, rd_d;

    always_comb begin
        rd_d      = rd_q;
        rd_d.done = 1'b0;
        case (rd_q.state)
            RD_IDLE: begin
                if (go) begin
                    rd_d.sh    = lat;
                    rd_d.cnt   = IDX_W'(STAGES - 1);
                    rd_d.state = RD_SHIFT;
                end
            end
            RD_SHIFT: begin
                if (rd_q.cnt == '0) begin
                    rd_d.state = RD_IDLE;
                    rd_d.done  = 1'b1;
                end else begin
                    rd_d.sh  = rd_q.sh >> 1;
                    rd_d.cnt = rd_q.cnt - 1'b1;
                end
            end
            default: rd_d.state = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= rd_t'{state: RD_IDLE, sh: '0, cnt: '0, done: 1'b0};
        end else begin
            rd_q <= rd_d;
        end
    end

    assign ser_o  = rd_q.sh[0];
    assign busy_o = (rd_q.state == RD_SHIFT);
    assign done_o = rd_q.done;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o)); // R7

    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !busy_o) |=> busy_o); // R7

    AST_GO_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && rd_q.cnt != '0) |=> (busy_o && rd_q.cnt == $past(rd_q.cnt) - 1'b1)); // R9

endmodule

// File: rtl/glitch_capture.sv
module glitch_capture #(
    parameter int STAGES     = 18,
    parameter int TRIG_STAGE = 11,
    parameter int LAG        = 2,
    parameter int STAGE_PS   = 65,
    parameter int LEN_W      = 6,
    localparam int IDX_W     = $clog2(STAGES + 1),
    localparam int WPS_W     = $clog2(STAGES * STAGE_PS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rearm_i,
    input  logic             inj_go_i,
    input  logic [IDX_W-1:0] inj_stage_i,
    input  logic [LEN_W-1:0] inj_len_i,
    input  logic             rd_go_i,
    output logic             pass_o,
    output logic             hold_o,
    output logic             ser_o,
    output logic             rd_busy_o,
    output logic             rd_done_o,
    output logic [IDX_W-1:0] flip_cnt_o,
    output logic [WPS_W-1:0] width_ps_o,
    output logic             sat_o
);
    localparam logic [gwp_pkg::MAX_STAGES-1:0] IDLE_W = gwp_pkg::idle_word();
    localparam logic IDLE_TAP = IDLE_W[TRIG_STAGE-1];

    logic              clr;
    logic              flag;
    logic              hold;
    logic              tap;
    logic [STAGES-1:0] lat;
    logic [IDX_W-1:0]  site;

    assign clr = rearm_i && !rd_busy_o;

    gwp_chain #(
        .STAGES (STAGES),
        .IDX_W  (IDX_W),
        .LEN_W  (LEN_W),
        .TRIG   (TRIG_STAGE)
    ) chain_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .go     (inj_go_i),
        .flag   (flag),
        .hold   (hold),
        .sel    (inj_stage_i),
        .len    (inj_len_i),
        .lat_o  (lat),
        .site_o (site),
        .tap_o  (tap)
    );

    gwp_trigger #(
        .LAG      (LAG),
        .IDLE_TAP (IDLE_TAP)
    ) trig_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .tap    (tap),
        .flag_o (flag),
        .hold_o (hold)
    );

    gwp_decode #(
        .STAGES   (STAGES),
        .IDX_W    (IDX_W),
        .WPS_W    (WPS_W),
        .STAGE_PS (STAGE_PS)
    ) dec_i (
        .lat     (lat),
        .site    (site),
        .hold    (hold),
        .cnt_o   (flip_cnt_o),
        .width_o (width_ps_o),
        .sat_o   (sat_o)
    );

    gwp_readout #(
        .STAGES (STAGES),
        .IDX_W  (IDX_W)
    ) rd_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (rd_go_i),
        .lat    (lat),
        .ser_o  (ser_o),
        .busy_o (rd_busy_o),
        .done_o (rd_done_o)
    );

    assign hold_o = hold;
    assign pass_o = !hold;

    AST_REARM_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (rearm_i && rd_busy_o && hold_o) |=> hold_o); // R8

    AST_REARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rearm_i && !rd_busy_o) |=> (pass_o && flip_cnt_o == '0)); // R8

    AST_SAT_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        sat_o |-> (hold_o && flip_cnt_o != '0)); // R6

endmodule

// File: tb/glitch_capture_tb_top.sv
module glitch_capture_tb_top;
    localparam int ST = 18;
    localparam int TR = 11;
    localparam int LG = 2;
    localparam int PS = 65;
    localparam int LW = 6;
    localparam int IW = $clog2(ST + 1);
    localparam int WW = $clog2(ST * PS + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rearm = 1'b0;
    logic          inj_go = 1'b0;
    logic [IW-1:0] inj_stage = '0;
    logic [LW-1:0] inj_len = '0;
    logic          rd_go = 1'b0;
    logic          pass_w, hold_w, ser_w, busy_w, done_w, sat_w;
    logic [IW-1:0] cnt_w;
    logic [WW-1:0] width_w;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    glitch_capture #(
        .STAGES(ST), .TRIG_STAGE(TR), .LAG(LG), .STAGE_PS(PS), .LEN_W(LW)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .rearm_i(rearm), .inj_go_i(inj_go),
        .inj_stage_i(inj_stage), .inj_len_i(inj_len), .rd_go_i(rd_go),
        .pass_o(pass_w), .hold_o(hold_w), .ser_o(ser_w), .rd_busy_o(busy_w),
        .rd_done_o(done_w), .flip_cnt_o(cnt_w), .width_ps_o(width_w), .sat_o(sat_w)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [ST-1:0] snap_of(input int k, input int len);
        logic [ST-1:0] v;
        int lo, hi;
        lo = (k > TR + 2 + LG - len) ? k : TR + 2 + LG - len;
        hi = TR + 1 + LG;
        for (int i = 1; i <= ST; i++) begin
            v[i-1] = (i % 2 == 1) ^ ((len > 0) && (i >= lo) && (i <= hi));
        end
        return v;
    endfunction

    // R7 / R9: serial readout, optionally pulsing rd_go mid-way
    task automatic read_all(output logic [ST-1:0] v, input bit poke);
        @(negedge clk) rd_go = 1'b1;
        @(negedge clk) rd_go = 1'b0;
        for (int m = 0; m < ST; m++) begin
            v[m] = ser_w;
            chk(busy_w == 1'b1, "R7 busy during shift", int'(busy_w), 1);
            if (poke && m == 5) rd_go = 1'b1;
            if (poke && m == 6) rd_go = 1'b0;
            @(negedge clk);
        end
        chk(busy_w == 1'b0, poke ? "R9 busy length" : "R7 busy length", int'(busy_w), 0);
        chk(done_w == 1'b1, "R7 done pulse", int'(done_w), 1);
        @(negedge clk);
        chk(done_w == 1'b0, "R7 done single", int'(done_w), 0);
    endtask

    task automatic do_rearm();
        @(negedge clk) rearm = 1'b1;
        @(negedge clk) rearm = 1'b0;
        chk(hold_w == 1'b0 && pass_w == 1'b1, "R8 rearm controls", int'(hold_w), 0);
        chk(cnt_w == '0, "R8 rearm count", int'(cnt_w), 0);
    endtask

    task automatic t_reset();
        logic [ST-1:0] v;
        chk(pass_w == 1'b1 && hold_w == 1'b0, "R1 controls", int'(hold_w), 0);
        chk(busy_w == 1'b0 && done_w == 1'b0, "R1 readout idle", int'(busy_w), 0);
        chk(cnt_w == '0 && width_w == '0 && sat_w == 1'b0, "R1 decode zero", int'(cnt_w), 0);
        read_all(v, 1'b0);
        chk(v == snap_of(1, 0), "R1 rest pattern", int'(v), int'(snap_of(1, 0)));
    endtask

    task automatic t_capture(input int k, input int len, input bit poke);
        logic [ST-1:0] v, v2;
        int seen, ecnt;
        do_rearm();
        @(negedge clk);
        inj_go = 1'b1; inj_stage = IW'(k); inj_len = LW'(len);
        @(negedge clk) inj_go = 1'b0;
        seen = 1;
        while (!hold_w && seen < 100) begin
            @(negedge clk);
            seen++;
        end
        chk(seen == TR + 3 + LG - k, "R3 freeze edge", seen, TR + 3 + LG - k);
        chk(pass_w == 1'b0, "R3 pass off", int'(pass_w), 0);
        ecnt = (len < TR + 2 + LG - k) ? len : TR + 2 + LG - k;
        chk(int'(cnt_w) == ecnt, "R5 flip count", int'(cnt_w), ecnt);
        chk(int'(width_w) == ecnt * PS, "R5 width", int'(width_w), ecnt * PS);
        chk(sat_w == (len >= TR + 2 + LG - k), "R6 saturation", int'(sat_w),
            int'(len >= TR + 2 + LG - k));
        read_all(v, poke);
        chk(v == snap_of(k, len), "R2 snapshot", int'(v), int'(snap_of(k, len)));
        // R10 / R4: a second injection and idle time leave the snapshot alone
        @(negedge clk);
        inj_go = 1'b1; inj_stage = IW'(1); inj_len = LW'(5);
        @(negedge clk) inj_go = 1'b0;
        repeat (25) @(negedge clk);
        chk(hold_w == 1'b1, "R4 still held", int'(hold_w), 1);
        chk(int'(cnt_w) == ecnt, "R10 count kept", int'(cnt_w), ecnt);
        read_all(v2, 1'b0);
        chk(v2 == v, "R4 snapshot kept", int'(v2), int'(v));
    endtask

    task automatic t_rearm_busy();
        logic [ST-1:0] v;
        int c0;
        c0 = int'(cnt_w);
        @(negedge clk) rd_go = 1'b1;
        @(negedge clk) rd_go = 1'b0;
        repeat (3) @(negedge clk);
        rearm = 1'b1;
        @(negedge clk) rearm = 1'b0;
        chk(hold_w == 1'b1, "R8 rearm ignored while busy", int'(hold_w), 1);
        while (busy_w) @(negedge clk);
        chk(int'(cnt_w) == c0, "R8 count after ignored rearm", int'(cnt_w), c0);
        read_all(v, 1'b0);
        chk(v == snap_of(4, 3), "R8 snapshot after ignored rearm", int'(v), int'(snap_of(4, 3)));
        do_rearm();
        read_all(v, 1'b0);
        chk(v == snap_of(1, 0), "R8 rest after rearm", int'(v), int'(snap_of(1, 0)));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_capture(2, 2, 1'b0);
        t_capture(3, 12, 1'b1);
        t_capture(5, 1, 1'b0);
        t_capture(1, 20, 1'b0);
        t_capture(8, 3, 1'b1);
        t_capture(10, 6, 1'b0);
        t_capture(4, 3, 1'b0);
        t_rearm_busy();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule